// File: doc/BRIEF.md
# Event Thread Spawner

The spawner turns three kinds of event into requests to start a handler thread on one of several processing engines: the end of reset, a match between a free-running timer and a compare value, and a set of external interrupt lines. Each accepted event leaves a pending bit. The block serves pending events one at a time. For each one it raises destination requests toward the interconnect arbiter. When the arbiter grants a destination, the block sends a two-beat migration payload to that engine.

An interrupt can be blocked by its mask bit. An interrupt that is not masked is routed in one of two ways. It can go to a fixed engine number, or it can go to whichever engine is granted first. In the second case the block requests every destination at once and withdraws all of them on the first grant. The reset event always goes to engine 0. The timer event always uses the first-granted method. The configuration comes in on plain input ports. A route is sampled when service of an event starts.

Top module: `evt_spawner`

## Requirements
- R1: When synchronous reset is released, the first request is `dst_req == 8'h01`, which is engine 0 only. Its payload code is 0. No request or payload appears while reset is held.
- R2: An interrupt whose `irq_mask` bit is 1 creates no pending event, and it never produces a request.
- R3: An unmasked interrupt with `irq_any[i] == 0` raises exactly one request bit. That bit is the engine number held in `irq_eng[3*i +: 3]`.
- R4: An interrupt with `irq_any[i] == 1`, and every timer event, raises all request bits at once (`8'hFF`).
- R5: In the cycle after a grant on a requested line, all requests are low. `pl_eng` names the granted engine for both payload beats.
- R6: A request stays asserted and unchanged until one of its own lines is granted. A grant on a line that is not requested is ignored.
- R7: The timer is 0 during reset and counts up by one on every clock after reset. When it equals `tmr_cmp`, a timer event is spawned with code 1.
- R8: A pending bit clears only when the payload for its event completes. Repeated pulses on an event that is already pending give a single spawn.
- R9: Pending events are served in fixed priority order: reset first, then the timer, then the interrupts from the lowest index to the highest.
- R10: The payload follows the grant as two beats on consecutive cycles. Beat 0 carries the event code. The codes are 0 for reset, 1 for the timer, and 2+i for interrupt i. Beat 1 carries the timer value from the grant cycle and is the only beat with `pl_last` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_irq | input | 4 | Interrupt lines; a high cycle raises the event |
| irq_mask | input | 4 | 1 blocks the corresponding interrupt |
| irq_any | input | 4 | 1 = first-granted engine, 0 = fixed engine |
| irq_eng | input | 12 | Fixed engine number per interrupt, 3 bits each |
| tmr_cmp | input | 32 | Timer compare value |
| dst_gnt | input | 8 | Grants from the arbiter, one bit per engine |
| dst_req | output | 8 | Destination requests, one bit per engine |
| pl_valid | output | 1 | Payload beat valid |
| pl_last | output | 1 | Marks the final payload beat |
| pl_data | output | 32 | Payload beat contents |
| pl_eng | output | 3 | Engine that receives the payload |

## Verification
On every cycle the assertions check the shape of the requests: no request, one bit, or all bits. They also check that a request holds until it is granted, that it is withdrawn after a grant, and that two beats follow each grant. Further checks confirm that a pending bit survives until its completion, that a masked line never becomes pending, and that a compare match always sets the timer pending bit. Some properties need a sequence of stimulus and only the bench scenarios can show them. These are the service order when several events are pending at once, the merging of repeated pulses, the code and timestamp values in the payload, and the routing chosen from the configuration.

// File: rtl/evtsp_pkg.sv
// Shared types for the event thread spawner.
package evtsp_pkg;
    // Dispatcher phases: idle, requesting, first beat, last beat.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_BEAT0 = 2'd2,
        ST_BEAT1 = 2'd3
    } disp_state_e;
endpackage

// File: rtl/evtsp_timer.sv
// Free-running timer with a compare match.
// Assumes: synchronous active-low reset; the compare value may change at any time.
module evtsp_timer #(
    parameter int TMR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMR_W-1:0] cmp,
    output logic [TMR_W-1:0] tmr,
    output logic             hit
);
    // Count every clock after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) tmr <= '0;
        else        tmr <= tmr + 1'b1;
    end

    // Equality with the compare register.
    always_comb hit = (tmr == cmp);
endmodule

// File: rtl/evtsp_pending.sv
// Pending event register with a fixed-priority pick (lowest index wins).
// Bit 0 is the reset event and is set while reset is held. A set in the same
// cycle as a clear leaves the bit set.
module evtsp_pending #(
    parameter int NUM_EV = 6,
    localparam int IDX_W = $clog2(NUM_EV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] set_ev,
    input  logic [NUM_EV-1:0] clr_ev,
    output logic [NUM_EV-1:0] pend,
    output logic              pick_valid,
    output logic [IDX_W-1:0]  pick_idx
);
    localparam logic [NUM_EV-1:0] EV_RESET = NUM_EV'(1);

    // Hold pending bits; clear on completion, set on a new event.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= EV_RESET;
        else        pend <= (pend & ~clr_ev) | set_ev;
    end

    // Pick the lowest-index pending event.
    always_comb begin
        pick_idx = '0;
        for (int k = NUM_EV - 1; k >= 0; k--) begin
            if (pend[k]) pick_idx = IDX_W'(k);
        end
        pick_valid = |pend;
    end

    generate
        for (genvar k = 0; k < NUM_EV; k++) begin : g_hold
            // R8: a pending bit survives until its completion clears it
            p_hold_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
                pend[k] && !clr_ev[k] |=> pend[k]);
        end
    endgenerate
endmodule

// File: rtl/evtsp_dispatch.sv
// Serves one event at a time: it latches the route, raises the requests,
// captures the grant and the timestamp, then drives two payload beats.
// Assumes: the arbiter grants at most one line per cycle; if more than one
// requested line is granted, the lowest one is taken.
module evtsp_dispatch
    import evtsp_pkg::*;
#(
    parameter int NUM_ENG = 8,
    parameter int NUM_EV  = 6,
    parameter int TMR_W   = 32,
    localparam int ENG_W  = $clog2(NUM_ENG),
    localparam int IDX_W  = $clog2(NUM_EV)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pick_valid,
    input  logic [IDX_W-1:0]   pick_idx,
    input  logic [NUM_EV-1:0]  ev_any,
    input  logic [ENG_W-1:0]   ev_eng [NUM_EV],
    input  logic [TMR_W-1:0]   tmr,
    input  logic [NUM_ENG-1:0] gnt,
    output logic [NUM_ENG-1:0] req,
    output logic [NUM_EV-1:0]  clr_ev,
    output logic               pl_valid,
    output logic               pl_last,
    output logic [TMR_W-1:0]   pl_data,
    output logic [ENG_W-1:0]   pl_eng
);
    localparam logic [NUM_ENG-1:0] ENG_ONE = NUM_ENG'(1);
    localparam logic [NUM_EV-1:0]  EV_ONE  = NUM_EV'(1);

    disp_state_e        state;
    logic [IDX_W-1:0]   cur_idx;
    logic [NUM_ENG-1:0] cur_req;
    logic [ENG_W-1:0]   win_eng;
    logic [TMR_W-1:0]   stamp;
    logic [NUM_ENG-1:0] hitv;
    logic [ENG_W-1:0]   hit_eng;

    // Granted lines among those requested; lowest one wins.
    always_comb begin
        hitv    = req & gnt;
        hit_eng = '0;
        for (int e = NUM_ENG - 1; e >= 0; e--) begin
            if (hitv[e]) hit_eng = ENG_W'(e);
        end
    end

    // Phase sequencing and latching of route, grant and timestamp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_idx <= '0;
            cur_req <= '0;
            win_eng <= '0;
            stamp   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (pick_valid) begin
                    cur_idx <= pick_idx;
                    cur_req <= ev_any[pick_idx] ? '1 : (ENG_ONE << ev_eng[pick_idx]);
                    state   <= ST_REQ;
                end
                ST_REQ: if (|hitv) begin
                    win_eng <= hit_eng;
                    stamp   <= tmr;
                    state   <= ST_BEAT0;
                end
                ST_BEAT0: state <= ST_BEAT1;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from the phase.
    always_comb begin
        req      = (state == ST_REQ) ? cur_req : '0;
        pl_valid = (state == ST_BEAT0) || (state == ST_BEAT1);
        pl_last  = (state == ST_BEAT1);
        pl_data  = (state == ST_BEAT0) ? TMR_W'(cur_idx) : stamp;
        pl_eng   = win_eng;
        clr_ev   = (state == ST_BEAT1) ? (EV_ONE << cur_idx) : '0;
    end

    // R4: requests are either a single line or all lines
    p_req_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req) || (&req));
    // R6: an ungranted request is held unchanged
    p_req_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) && !(|(req & gnt)) |=> req == $past(req));
    // R5: a grant withdraws every request and starts the payload
    p_withdraw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        |(req & gnt) |=> (req == '0) && pl_valid && !pl_last);
    // R10: the first beat is always followed by the flagged last beat
    p_two_beats_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pl_valid && !pl_last |=> pl_valid && pl_last);
    // R5: requests and payload never overlap
    p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !((|req) && pl_valid));
endmodule

// File: rtl/evt_spawner.sv
// Event thread spawner top. It maps reset, the timer match and the interrupt
// lines onto event slots (0 reset, 1 timer, 2+i interrupt i), fixes the
// routes of the reset and timer events, and wires timer, pending and dispatch.
// Assumes: configuration inputs are static while an event is being served,
// or are allowed to take effect only for the next event.
module evt_spawner #(
    parameter int NUM_ENG = 8,
    parameter int NUM_IRQ = 4,
    parameter int TMR_W   = 32,
    localparam int ENG_W  = $clog2(NUM_ENG),
    localparam int NUM_EV = NUM_IRQ + 2,
    localparam int IDX_W  = $clog2(NUM_EV)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_IRQ-1:0]       ev_irq,
    input  logic [NUM_IRQ-1:0]       irq_mask,
    input  logic [NUM_IRQ-1:0]       irq_any,
    input  logic [NUM_IRQ*ENG_W-1:0] irq_eng,
    input  logic [TMR_W-1:0]         tmr_cmp,
    input  logic [NUM_ENG-1:0]       dst_gnt,
    output logic [NUM_ENG-1:0]       dst_req,
    output logic                     pl_valid,
    output logic                     pl_last,
    output logic [TMR_W-1:0]         pl_data,
    output logic [ENG_W-1:0]         pl_eng
);
    logic [TMR_W-1:0]  tmr;
    logic              tmr_hit;
    logic [NUM_EV-1:0] set_ev;
    logic [NUM_EV-1:0] clr_ev;
    logic [NUM_EV-1:0] pend;
    logic              pick_valid;
    logic [IDX_W-1:0]  pick_idx;
    logic [NUM_EV-1:0] ev_any;
    logic [ENG_W-1:0]  ev_eng [NUM_EV];

    // Event sources: masked interrupts, the timer match; reset is preloaded.
    always_comb set_ev = {ev_irq & ~irq_mask, tmr_hit, 1'b0};

    // Fixed routes for reset (engine 0) and timer (any engine).
    assign ev_any[0] = 1'b0;
    assign ev_eng[0] = '0;
    assign ev_any[1] = 1'b1;
    assign ev_eng[1] = '0;

    generate
        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_route
            assign ev_any[2+i] = irq_any[i];
            assign ev_eng[2+i] = irq_eng[i*ENG_W +: ENG_W];
            // R2: a masked line cannot make its event pending
            p_mask_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
                ev_irq[i] && irq_mask[i] && !pend[2+i] |=> !pend[2+i]);
        end
    endgenerate

    evtsp_timer #(.TMR_W(TMR_W)) u_timer (
        .clk (clk),
        .rst_n (rst_n),
        .cmp (tmr_cmp),
        .tmr (tmr),
        .hit (tmr_hit)
    );

    evtsp_pending #(.NUM_EV(NUM_EV)) u_pending (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_ev     (set_ev),
        .clr_ev     (clr_ev),
        .pend       (pend),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx)
    );

    evtsp_dispatch #(
        .NUM_ENG (NUM_ENG),
        .NUM_EV  (NUM_EV),
        .TMR_W   (TMR_W)
    ) u_dispatch (
        .clk        (clk),
        .rst_n      (rst_n),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx),
        .ev_any     (ev_any),
        .ev_eng     (ev_eng),
        .tmr        (tmr),
        .gnt        (dst_gnt),
        .req        (dst_req),
        .clr_ev     (clr_ev),
        .pl_valid   (pl_valid),
        .pl_last    (pl_last),
        .pl_data    (pl_data),
        .pl_eng     (pl_eng)
    );

    // R7: a compare match always leaves the timer event pending
    p_timer_spawn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tmr == tmr_cmp |=> pend[1]);
endmodule

// File: tb/sim_evt_spawner.sv
`timescale 1ns/1ps
module sim_evt_spawner;
    localparam int NE = 8;
    localparam int NI = 4;
    localparam int TW = 32;
    localparam int EW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NI-1:0] ev_irq;
    logic [NI-1:0] irq_mask;
    logic [NI-1:0] irq_any;
    logic [NI*EW-1:0] irq_eng;
    logic [TW-1:0] tmr_cmp;
    logic [NE-1:0] dst_gnt;
    logic [NE-1:0] dst_req;
    logic          pl_valid;
    logic          pl_last;
    logic [TW-1:0] pl_data;
    logic [EW-1:0] pl_eng;

    int checks = 0;
    int fails  = 0;
    logic [31:0] cnt;

    always #2.5 clk = ~clk;

    evt_spawner u0 (
        .clk (clk), .rst_n (rst_n), .ev_irq (ev_irq), .irq_mask (irq_mask),
        .irq_any (irq_any), .irq_eng (irq_eng), .tmr_cmp (tmr_cmp),
        .dst_gnt (dst_gnt), .dst_req (dst_req), .pl_valid (pl_valid),
        .pl_last (pl_last), .pl_data (pl_data), .pl_eng (pl_eng)
    );

    // Bench model of elapsed cycles since reset (expected timer value).
    always @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NE-1:0] exp_req(input bit any, input int eng);
        return any ? '1 : (NE'(1) << eng);
    endfunction

    // One-cycle pulse; on return the request of an idle spawner is visible.
    task automatic pulse(input logic [NI-1:0] lines);
        ev_irq = lines;
        @(negedge clk);
        ev_irq = '0;
        @(negedge clk);
    endtask

    // Grant engine g and check the withdrawal and both payload beats.
    task automatic serve(input logic [NE-1:0] xreq, input int g, input int code, input string tag);
        logic [31:0] ts;
        chk({tag, " request"}, 32'(dst_req), 32'(xreq));
        dst_gnt = NE'(1) << g;
        ts = cnt;
        @(negedge clk);
        dst_gnt = '0;
        chk({tag, " R5 withdraw"}, 32'(dst_req), 32'h0);
        chk({tag, " R10 beat0 flags"}, {30'h0, pl_valid, pl_last}, 32'h2);
        chk({tag, " R10 code"}, pl_data, 32'(code));
        chk({tag, " R5 engine"}, 32'(pl_eng), 32'(g));
        @(negedge clk);
        chk({tag, " R10 beat1 flags"}, {30'h0, pl_valid, pl_last}, 32'h3);
        chk({tag, " R10 stamp"}, pl_data, ts);
        @(negedge clk);
        chk({tag, " R10 end"}, {31'h0, pl_valid}, 32'h0);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; ev_irq = '0; irq_mask = '1; irq_any = '0;
        irq_eng = '0; tmr_cmp = '1; dst_gnt = '0;
        repeat (3) @(negedge clk);
        chk("R1 no request in reset", 32'(dst_req), 32'h0);
        chk("R1 no payload in reset", {31'h0, pl_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: grant on an unrequested line is ignored
        dst_gnt = 8'h08;
        repeat (3) begin
            @(negedge clk);
            chk("R6 held under foreign grant", 32'(dst_req), 32'h01);
        end
        dst_gnt = '0;
        serve(8'h01, 0, 0, "R1");
        @(negedge clk);
        chk("R1 single spawn", 32'(dst_req), 32'h0);

        // Fixed routes: irq0->6, irq1->5, irq2->7, irq3->2
        irq_mask = '0;
        irq_eng = {3'd2, 3'd7, 3'd5, 3'd6};
        pulse(4'b0100);
        serve(exp_req(0, 7), 7, 4, "R3");
        irq_any[1] = 1'b1;
        pulse(4'b0010);
        serve(exp_req(1, 0), 4, 3, "R4");
        irq_any[1] = 1'b0;

        irq_mask[0] = 1'b1;
        pulse(4'b0001);
        chk("R2 masked no request", 32'(dst_req), 32'h0);
        repeat (3) @(negedge clk);
        chk("R2 masked still quiet", 32'(dst_req), 32'h0);
        irq_mask[0] = 1'b0;

        // R7: timer compare three cycles ahead
        tmr_cmp = cnt + 3;
        repeat (4) @(negedge clk);
        chk("R7 not early", 32'(dst_req), 32'h0);
        @(negedge clk);
        tmr_cmp = '1;
        serve(8'hFF, 1, 1, "R7");

        // R9 / R8: several events pending while one waits for a grant
        pulse(4'b0001);
        chk("R9 first irq0", 32'(dst_req), 32'(exp_req(0, 6)));
        ev_irq = 4'b1010; @(negedge clk);
        ev_irq = 4'b0000; @(negedge clk);
        ev_irq = 4'b0010; @(negedge clk);
        ev_irq = 4'b0000;
        tmr_cmp = cnt + 2;
        repeat (4) begin
            @(negedge clk);
            chk("R6 held while others pend", 32'(dst_req), 32'(exp_req(0, 6)));
        end
        tmr_cmp = '1;
        serve(exp_req(0, 6), 6, 2, "R9 irq0");
        @(negedge clk);
        serve(8'hFF, 3, 1, "R9 timer");
        @(negedge clk);
        serve(exp_req(0, 5), 5, 3, "R9 irq1");
        @(negedge clk);
        serve(exp_req(0, 2), 2, 5, "R9 irq3");
        repeat (3) @(negedge clk);
        chk("R8 repeated pulses coalesce", 32'(dst_req), 32'h0);

        // Random routing mix
        for (int n = 0; n < 60; n++) begin
            int i, e, g;
            bit m, a;
            i = $urandom % NI;
            m = ($urandom % 4) == 0;
            a = $urandom % 2;
            e = $urandom % NE;
            irq_mask[i] = m;
            irq_any[i] = a;
            irq_eng[i*EW +: EW] = EW'(e);
            pulse(NI'(1) << i);
            if (m) begin
                repeat (2) @(negedge clk);
                chk("R2 random masked", 32'(dst_req), 32'h0);
            end else begin
                g = a ? int'($urandom % NE) : e;
                serve(exp_req(a, e), g, 2 + i, a ? "R4 random" : "R3 random");
                @(negedge clk);
            end
            irq_mask[i] = 1'b0;
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule